// File: doc/BRIEF.md
# Addressed Three-Wire Display Frame Receiver

This block takes display and control frames from a host over a three-wire synchronous link: a chip-enable line, a serial clock and a data line. While chip enable is low, the block shifts in an 8-bit device address. When chip enable rises, the payload phase begins and every rising serial-clock edge samples one payload bit. When chip enable falls, the frame ends. If both the address and the bit count are right, the captured frame is committed.

Each frame has 96 payload bits. The display bits come first. The last two bits are direction bits, and they pick which slice of a 300-bit display memory the frame writes. The first frame also carries an 11-bit control word. Its fields set the sleep mode, the key-line/segment selection, the number of general-purpose ports, segment blanking, the bias and the duty. The duty setting decides how the 300 display bits are split across the frames: three frames in 1/3 duty and four frames in 1/4 duty.

All serial inputs pass through two-flop synchronisers into the system clock domain. Edges are detected on the synchronised copies. Bits are collected in a shadow store, and the shadow is copied into the display memory or control register only when the frame closes. A separate panel-reset input drives a blanking output. Frames are still received while that input is held low.

Top module: `frm_rx`

## Requirements
- R1: While `rst` is high, `disp_mem`, all control outputs and `frame_done` are 0, and `disp_blank` is 1.
- R2: The address is 8 bits, sent least significant bit first while `ser_ce` is low and sampled on rising `ser_clk`. A frame is committed only if the last 8 address bits equal 0x42. Any other address leaves every output unchanged and gives no `frame_done`.
- R3: A frame is committed only if exactly 96 payload bits arrive while `ser_ce` is high. A frame with 95 or 97 bits leaves every output unchanged and gives no `frame_done`.
- R4: Nothing in `disp_mem` or the control outputs changes while a frame is being received. Updates happen only after `ser_ce` falls.
- R5: Payload bits 94 and 95 (0-based, in transmission order) are the direction bits. The frame index is bit94 + 2·bit95, so the transmitted pairs 00, 10, 01 and 11 select frames 0, 1, 2 and 3.
- R6: In 1/3 duty, frames 0, 1 and 2 write display bits 0–77, 78–152 and 153–227. Payload bit k lands at base+k. Frame 3 is discarded with no `frame_done`.
- R7: In 1/4 duty, frames 0–3 write display bits 0–75, 76–151, 152–227 and 228–299. Payload bit k lands at base+k.
- R8: Frame 0 loads the control word from payload bits 83..93 in this order: S0, S1, K0, K1, P0, P1, P2, P3, SC, DR, DT. The outputs are `ctrl_sleep`={S0,S1}, `ctrl_keysel`={K0,K1}, `ctrl_ports`={P0,P1,P2,P3}, `ctrl_seg_off`=SC, `ctrl_bias3`=DR and `ctrl_duty4`=DT. Frames 1–3 never change the control outputs, whatever those bits hold.
- R9: Frame 0 uses the DT bit it carries to choose its own display slice: 78 bits when DT=0 and 76 bits when DT=1. Frames 1–3 use the stored `ctrl_duty4`.
- R10: `frame_done` is a single-cycle pulse, given once for each committed frame.
- R11: `disp_blank` follows the inverse of the synchronised `panel_rst_n`. Frames are received and committed normally while `panel_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Serial chip enable: low during the address phase, high during the payload phase |
| ser_clk | input | 1 | Serial bit clock; bits are sampled on its rising edge |
| ser_din | input | 1 | Serial data |
| panel_rst_n | input | 1 | Active-low panel reset; drives blanking only |
| disp_mem | output | 300 | Display memory |
| ctrl_sleep | output | 2 | Sleep mode field {S0,S1} |
| ctrl_keysel | output | 2 | Key-line/segment select field {K0,K1} |
| ctrl_ports | output | 4 | General-purpose port count field {P0..P3} |
| ctrl_seg_off | output | 1 | All-segments-off control |
| ctrl_bias3 | output | 1 | 1 = 1/3 bias, 0 = 1/2 bias |
| ctrl_duty4 | output | 1 | 1 = 1/4 duty, 0 = 1/3 duty |
| frame_done | output | 1 | One-cycle pulse per committed frame |
| disp_blank | output | 1 | Display blanking, high while the panel reset is active |

## Verification
The bench targets the commit gate in several ways:
- A wrong address and 95- and 97-bit frames must leave memory untouched. A design that counted loosely or compared only part of the address would overwrite a slice.
- Frame index 3 is sent in 1/3 duty. A design that ignored the frame limit would corrupt bits 228 and up.
- The bench switches duty in both directions through frame 0. A design that took frame 0's slice from the stale stored duty would write 78 bits where 76 are due, or the reverse.
- Ones are placed in the control positions of frames 1–3, so a design that loaded control from every frame shows it at once.
- A mid-frame look at the outputs catches any design that writes bits straight through instead of waiting for the chip-enable fall.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int PAYLOAD_BITS = 96;
  localparam int ADDR_BITS    = 8;
  localparam int DISP_BITS    = 300;
  localparam int SLICE_MAX    = 78;
  localparam int CTRL_POS     = 83;
  localparam int CTRL_BITS    = 11;
  localparam logic [7:0] DEV_ADDR = 8'h42;

  typedef struct packed {
    logic [1:0] sleep;
    logic [1:0] keysel;
    logic [3:0] ports;
    logic       seg_off;
    logic       bias3;
    logic       duty4;
  } ctrl_t;

  // first display bit written by frame f
  function automatic int seg_base(input bit quad, input int f);
    if (quad) return f * 76;
    if (f == 0) return 0;
    return 78 + (f - 1) * 75;
  endfunction

  // number of display bits carried by frame f
  function automatic int seg_len(input bit quad, input int f);
    if (quad) return (f == 3) ? 72 : 76;
    if (f == 0) return 78;
    if (f < 3) return 75;
    return 0;
  endfunction

  // frame that owns display bit j, -1 when none
  function automatic int seg_frame(input bit quad, input int j);
    for (int f = 0; f < 4; f++) begin
      if (j >= seg_base(quad, f) && j < seg_base(quad, f) + seg_len(quad, f))
        return f;
    end
    return -1;
  endfunction

  // control bits in transmission order: S0 S1 K0 K1 P0 P1 P2 P3 SC DR DT
  function automatic ctrl_t ctrl_decode(input logic [CTRL_BITS-1:0] b);
    ctrl_t c;
    c.sleep   = {b[0], b[1]};
    c.keysel  = {b[2], b[3]};
    c.ports   = {b[4], b[5], b[6], b[7]};
    c.seg_off = b[8];
    c.bias3   = b[9];
    c.duty4   = b[10];
    return c;
  endfunction

endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/frm_shift.sv
module frm_shift
  import frm_pkg::*;
#(
  parameter int         P_BITS = PAYLOAD_BITS,
  parameter int         A_BITS = ADDR_BITS,
  parameter int         S_MAX  = SLICE_MAX,
  parameter int         C_POS  = CTRL_POS,
  parameter int         C_BITS = CTRL_BITS,
  parameter logic [7:0] MY_ADDR = DEV_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_lvl,
  input  logic              sck_lvl,
  input  logic              din_lvl,
  output logic              commit,
  output logic [S_MAX-1:0]  disp_sh,
  output logic [C_BITS-1:0] ctl_sh,
  output logic [1:0]        dir_sh
);

  localparam int CNT_MAX = P_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              ce_d, sck_d;
  logic              ce_rise, ce_fall, sck_rise;
  logic [A_BITS-1:0] addr_sh;
  logic              addr_ok;
  logic [CNT_W-1:0]  cnt;
  logic              wr;

  assign ce_rise  = ce_lvl & ~ce_d;
  assign ce_fall  = ~ce_lvl & ce_d;
  assign sck_rise = sck_lvl & ~sck_d;
  assign wr       = sck_rise & ce_lvl & ~ce_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d    <= 1'b0;
      sck_d   <= 1'b0;
      addr_sh <= '0;
      addr_ok <= 1'b0;
      cnt     <= '0;
      commit  <= 1'b0;
    end else begin
      ce_d   <= ce_lvl;
      sck_d  <= sck_lvl;
      commit <= 1'b0;
      if (sck_rise && !ce_lvl)
        addr_sh <= {din_lvl, addr_sh[A_BITS-1:1]};
      if (ce_rise) begin
        addr_ok <= (addr_sh == MY_ADDR);
        cnt     <= '0;
      end else if (wr && cnt != CNT_W'(CNT_MAX)) begin
        cnt <= cnt + 1'b1;
      end
      if (ce_fall)
        commit <= addr_ok && (cnt == CNT_W'(P_BITS));
    end
  end

  // one flop per payload position that is kept
  for (genvar p = 0; p < P_BITS; p++) begin : g_pos
    if (p < S_MAX) begin : g_disp
      always_ff @(posedge clk) begin
        if (rst) disp_sh[p] <= 1'b0;
        else if (wr && cnt == CNT_W'(p)) disp_sh[p] <= din_lvl;
      end
    end else if (p >= C_POS && p < C_POS + C_BITS) begin : g_ctl
      always_ff @(posedge clk) begin
        if (rst) ctl_sh[p-C_POS] <= 1'b0;
        else if (wr && cnt == CNT_W'(p)) ctl_sh[p-C_POS] <= din_lvl;
      end
    end else if (p >= P_BITS - 2) begin : g_dir
      always_ff @(posedge clk) begin
        if (rst) dir_sh[p-(P_BITS-2)] <= 1'b0;
        else if (wr && cnt == CNT_W'(p)) dir_sh[p-(P_BITS-2)] <= din_lvl;
      end
    end
  end

  // R4
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_lvl |=> $stable(disp_sh) && $stable(ctl_sh) && $stable(dir_sh));

  // R10
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

endmodule

// File: rtl/frm_bank.sv
module frm_bank
  import frm_pkg::*;
#(
  parameter int D_BITS = DISP_BITS,
  parameter int S_MAX  = SLICE_MAX,
  parameter int C_BITS = CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [S_MAX-1:0]  disp_sh,
  input  logic [C_BITS-1:0] ctl_sh,
  input  logic [1:0]        dir_sh,
  output logic [D_BITS-1:0] disp_q,
  output ctrl_t             ctrl_q,
  output logic              done_q
);

  ctrl_t new_ctrl;
  logic  duty_eff;
  logic  accept;

  assign new_ctrl = ctrl_decode(ctl_sh);
  assign duty_eff = (dir_sh == 2'd0) ? new_ctrl.duty4 : ctrl_q.duty4;
  assign accept   = commit && (duty_eff || dir_sh != 2'd3);

  for (genvar j = 0; j < D_BITS; j++) begin : g_bit
    localparam int F3 = seg_frame(1'b0, j);
    localparam int F4 = seg_frame(1'b1, j);
    localparam int O3 = (F3 < 0) ? 0 : j - seg_base(1'b0, F3);
    localparam int O4 = (F4 < 0) ? 0 : j - seg_base(1'b1, F4);
    logic hit3, hit4;
    if (F3 >= 0) begin : g_h3
      assign hit3 = !duty_eff && (dir_sh == 2'(F3));
    end else begin : g_n3
      assign hit3 = 1'b0;
    end
    if (F4 >= 0) begin : g_h4
      assign hit4 = duty_eff && (dir_sh == 2'(F4));
    end else begin : g_n4
      assign hit4 = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst)                  disp_q[j] <= 1'b0;
      else if (accept && hit3)  disp_q[j] <= disp_sh[O3];
      else if (accept && hit4)  disp_q[j] <= disp_sh[O4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept;
      if (accept && dir_sh == 2'd0) ctrl_q <= new_ctrl;
    end
  end

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit && dir_sh == 2'd0) |=> $stable(ctrl_q));

  // R4
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(disp_q));

  // R6
  extra_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && dir_sh == 2'd3 && !ctrl_q.duty4) |=> $stable(disp_q) && !done_q);

  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(commit));

endmodule

// File: rtl/frm_rx.sv
module frm_rx
  import frm_pkg::*;
#(
  parameter int         P_BITS  = PAYLOAD_BITS,
  parameter int         A_BITS  = ADDR_BITS,
  parameter int         D_BITS  = DISP_BITS,
  parameter int         S_MAX   = SLICE_MAX,
  parameter int         C_POS   = CTRL_POS,
  parameter int         C_BITS  = CTRL_BITS,
  parameter logic [7:0] MY_ADDR = DEV_ADDR,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_ce,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              panel_rst_n,
  output logic [D_BITS-1:0] disp_mem,
  output logic [1:0]        ctrl_sleep,
  output logic [1:0]        ctrl_keysel,
  output logic [3:0]        ctrl_ports,
  output logic              ctrl_seg_off,
  output logic              ctrl_bias3,
  output logic              ctrl_duty4,
  output logic              frame_done,
  output logic              disp_blank
);

  localparam int LINES = 4;

  logic [LINES-1:0]  lvl;
  logic              commit;
  logic [S_MAX-1:0]  disp_sh;
  logic [C_BITS-1:0] ctl_sh;
  logic [1:0]        dir_sh;
  ctrl_t             ctrl_q;

  frm_sync #(.N(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({panel_rst_n, ser_din, ser_clk, ser_ce}),
    .lvl (lvl)
  );

  frm_shift #(
    .P_BITS(P_BITS), .A_BITS(A_BITS), .S_MAX(S_MAX),
    .C_POS(C_POS), .C_BITS(C_BITS), .MY_ADDR(MY_ADDR)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .ce_lvl  (lvl[0]),
    .sck_lvl (lvl[1]),
    .din_lvl (lvl[2]),
    .commit  (commit),
    .disp_sh (disp_sh),
    .ctl_sh  (ctl_sh),
    .dir_sh  (dir_sh)
  );

  frm_bank #(.D_BITS(D_BITS), .S_MAX(S_MAX), .C_BITS(C_BITS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .disp_sh (disp_sh),
    .ctl_sh  (ctl_sh),
    .dir_sh  (dir_sh),
    .disp_q  (disp_mem),
    .ctrl_q  (ctrl_q),
    .done_q  (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) disp_blank <= 1'b1;
    else     disp_blank <= ~lvl[3];
  end

  assign ctrl_sleep   = ctrl_q.sleep;
  assign ctrl_keysel  = ctrl_q.keysel;
  assign ctrl_ports   = ctrl_q.ports;
  assign ctrl_seg_off = ctrl_q.seg_off;
  assign ctrl_bias3   = ctrl_q.bias3;
  assign ctrl_duty4   = ctrl_q.duty4;

endmodule

// File: tb/frm_rx_bench.sv
module frm_rx_bench;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, panel_rst_n = 1'b1;
  logic [299:0] disp_mem;
  logic [1:0] ctrl_sleep, ctrl_keysel;
  logic [3:0] ctrl_ports;
  logic ctrl_seg_off, ctrl_bias3, ctrl_duty4, frame_done, disp_blank;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int m_done = 0;
  logic [299:0] m_disp = '0;
  logic [10:0]  m_ctrl = '0;

  always #4 clk = ~clk;

  frm_rx u_frm_rx (
    .clk(clk), .rst(rst), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_din(ser_din),
    .panel_rst_n(panel_rst_n), .disp_mem(disp_mem), .ctrl_sleep(ctrl_sleep),
    .ctrl_keysel(ctrl_keysel), .ctrl_ports(ctrl_ports), .ctrl_seg_off(ctrl_seg_off),
    .ctrl_bias3(ctrl_bias3), .ctrl_duty4(ctrl_duty4), .frame_done(frame_done),
    .disp_blank(disp_blank)
  );

  always @(posedge clk) if (!rst && frame_done) done_cnt <= done_cnt + 1;

  // {addr, nbits, frame index, seed, control bits (bit k = payload 83+k)}
  localparam logic [35:0] VEC [12] = '{
    {8'h42, 7'd96, 2'd0, 8'd3,  11'b0_1_0_1010_10_01},
    {8'h42, 7'd96, 2'd1, 8'd5,  11'b0},
    {8'h42, 7'd96, 2'd2, 8'd9,  11'b0},
    {8'h42, 7'd96, 2'd3, 8'd11, 11'b0},
    {8'h43, 7'd96, 2'd1, 8'd13, 11'b0},
    {8'h42, 7'd95, 2'd2, 8'd17, 11'b0},
    {8'h42, 7'd97, 2'd1, 8'd19, 11'b0},
    {8'h42, 7'd96, 2'd0, 8'd23, 11'b1_0_1_0011_01_10},
    {8'h42, 7'd96, 2'd1, 8'd29, 11'b0},
    {8'h42, 7'd96, 2'd2, 8'd31, 11'b0},
    {8'h42, 7'd96, 2'd3, 8'd37, 11'b0},
    {8'h42, 7'd96, 2'd0, 8'd41, 11'b0_0_0_1100_11_11}
  };

  function automatic string req_of(input int v);
    case (v)
      0, 2:    return "R6";
      1:       return "R5";
      3:       return "R6 extra frame";
      4:       return "R2";
      5, 6:    return "R3";
      7, 11:   return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [99:0] mk(input logic [1:0] idx, input logic [7:0] seed,
                                      input logic [10:0] c);
    logic [99:0] p;
    for (int i = 0; i < 100; i++) p[i] = ((i * 13 + int'(seed) * 29) % 5) < 2;
    p[93:83] = (idx == 2'd0) ? c : 11'h7FF;
    p[94] = idx[0];
    p[95] = idx[1];
    return p;
  endfunction

  task automatic chk(input string tag, input logic [299:0] act, input logic [299:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_ctrl();
    return {m_ctrl[0], m_ctrl[1], m_ctrl[2], m_ctrl[3], m_ctrl[4], m_ctrl[5],
            m_ctrl[6], m_ctrl[7], m_ctrl[8], m_ctrl[9], m_ctrl[10]};
  endfunction

  function automatic logic [10:0] act_ctrl();
    return {ctrl_sleep, ctrl_keysel, ctrl_ports, ctrl_seg_off, ctrl_bias3, ctrl_duty4};
  endfunction

  task automatic model(input logic [7:0] addr, input int nbits, input logic [1:0] idx,
                       input logic [99:0] p);
    int b3 [4] = '{0, 78, 153, 0};
    int l3 [4] = '{78, 75, 75, 0};
    int b4 [4] = '{0, 76, 152, 228};
    int l4 [4] = '{76, 76, 76, 72};
    logic quad;
    quad = (idx == 2'd0) ? p[93] : m_ctrl[10];
    if (addr == 8'h42 && nbits == 96 && (quad || idx != 2'd3)) begin
      for (int k = 0; k < (quad ? l4[idx] : l3[idx]); k++)
        m_disp[(quad ? b4[idx] : b3[idx]) + k] = p[k];
      if (idx == 2'd0) m_ctrl = p[93:83];
      m_done++;
    end
  endtask

  task automatic send(input logic [7:0] addr, input int nbits, input logic [99:0] p,
                      input int peek);
    @(negedge clk);
    ser_ce = 1'b0;
    for (int a = 0; a < 8; a++) begin
      ser_din = addr[a];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ser_ce = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_din = p[i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
      if (i == peek) begin
        repeat (8) @(negedge clk);
        chk("R4 mid-frame memory", disp_mem, m_disp);
        chk("R4 mid-frame control", 300'(act_ctrl()), 300'(exp_ctrl()));
        chk("R4 mid-frame done", 300'(done_cnt), 300'(m_done));
      end
    end
    repeat (HALF) @(negedge clk);
    ser_ce = 1'b0;
    ser_din = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic run(input logic [7:0] addr, input int nbits, input logic [1:0] idx,
                     input logic [7:0] seed, input logic [10:0] c, input string tag,
                     input int peek);
    logic [99:0] p;
    p = mk(idx, seed, c);
    send(addr, nbits, p, peek);
    model(addr, nbits, idx, p);
    chk(tag, disp_mem, m_disp);
    chk("R8 control", 300'(act_ctrl()), 300'(exp_ctrl()));
    chk("R10 done count", 300'(done_cnt), 300'(m_done));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (8) @(negedge clk);
    chk("R1 reset memory", disp_mem, '0);
    chk("R1 reset control", 300'(act_ctrl()), '0);
    chk("R1 reset done", 300'(frame_done), '0);
    chk("R1 reset blank", 300'(disp_blank), 300'(1));
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 blank released", 300'(disp_blank), '0);

    for (int v = 0; v < 12; v++) begin
      logic [35:0] e;
      e = VEC[v];
      run(e[35:28], int'(e[27:21]), e[20:19], e[18:11], e[10:0], req_of(v), -1);
    end

    // R4: look at the outputs in the middle of a frame
    run(8'h42, 96, 2'd2, 8'd77, 11'b0, "R4 after commit", 50);

    // R11: receive while the panel reset is held low
    panel_rst_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 blank asserted", 300'(disp_blank), 300'(1));
    run(8'h42, 96, 2'd1, 8'd91, 11'b0, "R11 frame under panel reset", -1);
    panel_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 blank cleared", 300'(disp_blank), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule